// File: doc/BRIEF.md
# Staged Custom State Array

This block holds a small array of instruction-visible state elements that custom instructions read and write at fixed points of a processor pipeline. An instruction names the element it will write early, in stage 1. The new value only exists two stages later, in stage 3. The block carries this pending write from stage to stage alongside the instruction. At every step it follows the stall and flush status of the stage that holds the write. When the write reaches stage 3 unstalled and unflushed, it lands in the array.

Reads happen in stage 2. The read data is combinational from the array. If a read in stage 2 names an element that an older instruction in stage 3 is about to write, the block raises a stall request until that write has landed, because the read data would otherwise be stale. A second write port, not bound to any instruction, can update the array in any cycle. It is gated by the stage-3 stall and flush, and it loses to an instruction write aimed at the same element.

The element width and element count are parameters. The address width is derived from the element count. The core that hosts the block must stall stage 1 whenever stage 2 holds, and must stall stage 2 whenever stage 3 holds.

Top module: `stage_state_array`

## Requirements
- R1: After reset every element reads as zero, and no hazard is raised.
- R2: When `s1_wr_i` is high in an unstalled, unflushed stage-1 cycle with an in-range `s1_waddr_i`, the write is carried forward. It is committed with `s3_wdata_i` at the end of the first cycle in which it sits in stage 3 with `s3_stall_i` and `s3_flush_i` low. A stage-2 read of that element sees the value from the next cycle on.
- R3: A write request presented while `s1_stall_i` is high does not enter stage 2 in that cycle.
- R4: While stage 2 holds (`s2_stall_i` high or `s2_hazard_o` high), the pending write in stage 2 stays in place, and stage 3 receives no write from it.
- R5: While `s3_stall_i` is high, the pending write in stage 3 is not committed and stays pending. It commits in the first later cycle in which stage 3 is neither stalled nor flushed.
- R6: A flush of stage 1, 2 or 3 in a cycle where that stage holds the pending write discards the write, and the element keeps its old value.
- R7: `s2_hazard_o` is high exactly when `s2_rd_i` is high, a write is pending in stage 3, and its address equals `s2_raddr_i`.
- R8: The free-running port writes `ct_wdata_i` to element `ct_addr_i` at the end of a cycle with `ct_we_i` high, `s3_stall_i` low and `s3_flush_i` low. In any other cycle it has no effect.
- R9: When an instruction commit and a free-running write hit the same element in one cycle, the instruction value is stored. When they hit different elements, both are stored.
- R10: An address at or above the element count is out of range. Writes to it are dropped, they never create a pending write or a hazard, and reads of it return zero.
- R11: `s2_rdata_o` always shows the current contents of element `s2_raddr_i`. It shows zero when that address is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s1_wr_i | input | 1 | Instruction in stage 1 will write the array |
| s1_waddr_i | input | AW | Target element of that write |
| s1_stall_i | input | 1 | Stage 1 is stalled |
| s1_flush_i | input | 1 | Stage 1 is flushed |
| s2_rd_i | input | 1 | Instruction in stage 2 reads the array |
| s2_raddr_i | input | AW | Element read in stage 2 |
| s2_stall_i | input | 1 | Stage 2 is stalled by the core |
| s2_flush_i | input | 1 | Stage 2 is flushed |
| s2_rdata_o | output | W | Read data for stage 2 |
| s2_hazard_o | output | 1 | Stall request: the stage-2 read waits for a pending write |
| s3_wdata_i | input | W | Write data of the instruction in stage 3 |
| s3_stall_i | input | 1 | Stage 3 is stalled |
| s3_flush_i | input | 1 | Stage 3 is flushed |
| ct_we_i | input | 1 | Free-running write enable |
| ct_addr_i | input | AW | Free-running write element |
| ct_wdata_i | input | W | Free-running write data |

## Verification
The assertions check on every cycle the properties that can be seen from one cycle to the next. A stage-2 hold keeps the stage-2 pending write, and a stage-3 stall keeps the stage-3 write. A stall combined with a flush in stage 3 empties that stage. A commit is visible to a read of the same element one cycle later. A hazard never appears without a read, and out-of-range reads return zero. Only the bench scenarios can show the complete journey of a write through three stages. This covers the cycle in which it lands, the flushes in stage 1 and 2 that cancel it, the priority between the two write ports, and dropped out-of-range writes. A seeded random phase runs these against a bench model of the pipeline that obeys the stall ordering the core must keep.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  // Address width for an array of n elements (at least one bit).
  function automatic int unsigned addr_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when address a names an existing element of an n-element array.
  function automatic logic in_range(logic [31:0] a, int unsigned n);
    return a < n;
  endfunction

endpackage

// File: rtl/ssa_pend_stage.sv
// One pipeline slot carrying a pending write (valid flag and element address).
module ssa_pend_stage #(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_v_i,
  input  logic [AW-1:0] in_a_i,
  input  logic          hold_i,
  input  logic          flush_i,
  output logic          v_o,
  output logic [AW-1:0] a_o,
  output logic          fwd_o
);

  logic          v_q;
  logic [AW-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      a_q <= '0;
    end else if (hold_i) begin
      v_q <= v_q & ~flush_i;
    end else begin
      v_q <= in_v_i;
      a_q <= in_a_i;
    end
  end

  assign v_o   = v_q;
  assign a_o   = a_q;
  // The held write leaves this slot only when it is neither held nor flushed.
  assign fwd_o = v_q & ~flush_i & ~hold_i;

endmodule

// File: rtl/ssa_hazard.sv
// Read-after-pending-write detection for the stage-2 read.
module ssa_hazard #(
  parameter int AW = 3
) (
  input  logic          rd_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          pend_v_i,
  input  logic [AW-1:0] pend_a_i,
  output logic          hazard_o
);

  assign hazard_o = rd_i & pend_v_i & (pend_a_i == raddr_i);

endmodule

// File: rtl/ssa_store.sv
// Element storage with a prioritised instruction port and a free-running port.
module ssa_store #(
  parameter int W  = 16,
  parameter int N  = 6,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ia_we_i,
  input  logic [AW-1:0] ia_addr_i,
  input  logic [W-1:0]  ia_data_i,
  input  logic          cb_we_i,
  input  logic [AW-1:0] cb_addr_i,
  input  logic [W-1:0]  cb_data_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] cell_w [N];

  for (genvar g = 0; g < N; g++) begin : g_cell
    logic [W-1:0] cell_q;
    logic         hit_ia;
    logic         hit_cb;

    assign hit_ia = ia_we_i & (ia_addr_i == AW'(g));
    assign hit_cb = cb_we_i & (cb_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cell_q <= '0;
      else if (hit_ia) cell_q <= ia_data_i;
      else if (hit_cb) cell_q <= cb_data_i;
    end

    assign cell_w[g] = cell_q;
  end

  // Unmatched (out-of-range) addresses fall through to zero.
  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < N; e++) begin
      if (raddr_i == AW'(e)) rdata_o = cell_w[e];
    end
  end

endmodule

// File: rtl/stage_state_array.sv
module stage_state_array #(
  parameter  int W  = 16,
  parameter  int N  = 6,
  localparam int AW = ssa_pkg::addr_bits(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s1_wr_i,
  input  logic [AW-1:0] s1_waddr_i,
  input  logic          s1_stall_i,
  input  logic          s1_flush_i,
  input  logic          s2_rd_i,
  input  logic [AW-1:0] s2_raddr_i,
  input  logic          s2_stall_i,
  input  logic          s2_flush_i,
  output logic [W-1:0]  s2_rdata_o,
  output logic          s2_hazard_o,
  input  logic [W-1:0]  s3_wdata_i,
  input  logic          s3_stall_i,
  input  logic          s3_flush_i,
  input  logic          ct_we_i,
  input  logic [AW-1:0] ct_addr_i,
  input  logic [W-1:0]  ct_wdata_i
);

  localparam int NSLOT = 2;  // stage 2 and stage 3

  logic          slot_in_v [NSLOT];
  logic [AW-1:0] slot_in_a [NSLOT];
  logic          slot_hold [NSLOT];
  logic          slot_fl   [NSLOT];
  logic          slot_v    [NSLOT];
  logic [AW-1:0] slot_a    [NSLOT];
  logic          slot_fwd  [NSLOT];

  // Named events for the checker.
  logic          s1_capture_w;
  logic          inst_commit_w;
  logic          ct_commit_w;
  logic          p2_v, p3_v;
  logic [AW-1:0] p2_a, p3_a;

  assign s1_capture_w = s1_wr_i & ssa_pkg::in_range(32'(s1_waddr_i), N)
                      & ~s1_flush_i & ~s1_stall_i;

  assign slot_in_v[0] = s1_capture_w;
  assign slot_in_a[0] = s1_waddr_i;
  assign slot_hold[0] = s2_stall_i | s2_hazard_o;
  assign slot_fl[0]   = s2_flush_i;
  assign slot_in_v[1] = slot_fwd[0];
  assign slot_in_a[1] = slot_a[0];
  assign slot_hold[1] = s3_stall_i;
  assign slot_fl[1]   = s3_flush_i;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    ssa_pend_stage #(.AW(AW)) i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .in_v_i  (slot_in_v[k]),
      .in_a_i  (slot_in_a[k]),
      .hold_i  (slot_hold[k]),
      .flush_i (slot_fl[k]),
      .v_o     (slot_v[k]),
      .a_o     (slot_a[k]),
      .fwd_o   (slot_fwd[k])
    );
  end

  assign p2_v = slot_v[0];
  assign p2_a = slot_a[0];
  assign p3_v = slot_v[1];
  assign p3_a = slot_a[1];

  ssa_hazard #(.AW(AW)) i_hazard (
    .rd_i     (s2_rd_i),
    .raddr_i  (s2_raddr_i),
    .pend_v_i (p3_v),
    .pend_a_i (p3_a),
    .hazard_o (s2_hazard_o)
  );

  assign inst_commit_w = slot_fwd[1];
  assign ct_commit_w   = ct_we_i & ~s3_stall_i & ~s3_flush_i;

  ssa_store #(.W(W), .N(N), .AW(AW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ia_we_i   (inst_commit_w),
    .ia_addr_i (p3_a),
    .ia_data_i (s3_wdata_i),
    .cb_we_i   (ct_commit_w),
    .cb_addr_i (ct_addr_i),
    .cb_data_i (ct_wdata_i),
    .raddr_i   (s2_raddr_i),
    .rdata_o   (s2_rdata_o)
  );

endmodule

// File: rtl/ssa_chk.sv
module ssa_chk #(
  parameter int W  = 16,
  parameter int N  = 6,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s2_rd_i,
  input logic [AW-1:0] s2_raddr_i,
  input logic          s2_flush_i,
  input logic [W-1:0]  s2_rdata_o,
  input logic          s2_hazard_o,
  input logic [W-1:0]  s3_wdata_i,
  input logic          s3_stall_i,
  input logic          s3_flush_i,
  input logic          p2_v,
  input logic [AW-1:0] p2_a,
  input logic          p3_v,
  input logic [AW-1:0] p3_a
);

  AST_HAZARD_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_hazard_o |-> s2_rd_i); // R7

  AST_S2_HOLD_KEEPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_hazard_o && !s2_flush_i) |=> (p2_v == $past(p2_v) && p2_a == $past(p2_a))); // R4

  AST_S3_STALL_KEEPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_stall_i && !s3_flush_i) |=> (p3_v == $past(p3_v) && p3_a == $past(p3_a))); // R5

  AST_S3_FLUSH_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_stall_i && s3_flush_i) |=> !p3_v); // R6

  AST_COMMIT_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p3_v && !s3_stall_i && !s3_flush_i)
    |=> (s2_raddr_i != $past(p3_a)) || (s2_rdata_o == $past(s3_wdata_i))); // R2

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(s2_raddr_i) >= N) |-> (s2_rdata_o == '0)); // R10

endmodule

bind stage_state_array ssa_chk #(.W(W), .N(N), .AW(AW)) i_ssa_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .s2_rd_i     (s2_rd_i),
  .s2_raddr_i  (s2_raddr_i),
  .s2_flush_i  (s2_flush_i),
  .s2_rdata_o  (s2_rdata_o),
  .s2_hazard_o (s2_hazard_o),
  .s3_wdata_i  (s3_wdata_i),
  .s3_stall_i  (s3_stall_i),
  .s3_flush_i  (s3_flush_i),
  .p2_v        (p2_v),
  .p2_a        (p2_a),
  .p3_v        (p3_v),
  .p3_a        (p3_a)
);

// File: tb/test_stage_state_array.sv
`timescale 1ns/1ps
module test_stage_state_array;

  localparam int W  = 16;
  localparam int N  = 6;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          s1_wr, s1_stall, s1_flush;
  logic [AW-1:0] s1_waddr;
  logic          s2_rd, s2_stall, s2_flush;
  logic [AW-1:0] s2_raddr;
  logic [W-1:0]  s2_rdata;
  logic          s2_hazard;
  logic [W-1:0]  s3_wdata;
  logic          s3_stall, s3_flush;
  logic          ct_we;
  logic [AW-1:0] ct_addr;
  logic [W-1:0]  ct_wdata;

  always #10 clk = ~clk;  // 50 MHz

  stage_state_array #(.W(W), .N(N)) i_stage_state_array (
    .clk_i(clk), .rst_ni(rst_ni),
    .s1_wr_i(s1_wr), .s1_waddr_i(s1_waddr), .s1_stall_i(s1_stall), .s1_flush_i(s1_flush),
    .s2_rd_i(s2_rd), .s2_raddr_i(s2_raddr), .s2_stall_i(s2_stall), .s2_flush_i(s2_flush),
    .s2_rdata_o(s2_rdata), .s2_hazard_o(s2_hazard),
    .s3_wdata_i(s3_wdata), .s3_stall_i(s3_stall), .s3_flush_i(s3_flush),
    .ct_we_i(ct_we), .ct_addr_i(ct_addr), .ct_wdata_i(ct_wdata)
  );

  int unsigned nchk = 0, nfail = 0;
  bit          done = 1'b0;

  // Bench model of the requirements.
  logic [W-1:0]  mem_m [N];
  logic          m2v, m3v, haz_m;
  logic [AW-1:0] m2a, m3a;
  logic [W-1:0]  rd_seen;
  logic          hz_seen;

  function automatic logic [W-1:0] rd_m(logic [AW-1:0] a);
    return (int'(a) < N) ? mem_m[a] : '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    s1_wr = 0; s1_waddr = '0; s1_stall = 0; s1_flush = 0;
    s2_rd = 0; s2_raddr = '0; s2_stall = 0; s2_flush = 0;
    s3_wdata = '0; s3_stall = 0; s3_flush = 0;
    ct_we = 0; ct_addr = '0; ct_wdata = '0;
  endtask

  task automatic step();
    logic commit, hold2, fwd2;
    haz_m = s2_rd & m3v & (m3a == s2_raddr);
    if (s3_stall) s2_stall = 1'b1;            // core ordering contract
    if (s2_stall | haz_m) s1_stall = 1'b1;
    #2;
    rd_seen = s2_rdata;
    hz_seen = s2_hazard;
    check("R7 hazard", 32'(s2_hazard), 32'(haz_m));
    check("R11 read data", 32'(s2_rdata), 32'(rd_m(s2_raddr)));
    @(posedge clk); #1;
    commit = m3v & ~s3_flush & ~s3_stall;
    if (ct_we & ~s3_stall & ~s3_flush & (int'(ct_addr) < N)) mem_m[ct_addr] = ct_wdata;
    if (commit) mem_m[m3a] = s3_wdata;
    hold2 = s2_stall | haz_m;
    fwd2  = m2v & ~s2_flush & ~hold2;
    if (s3_stall) m3v = m3v & ~s3_flush;
    else begin m3v = fwd2; m3a = m2a; end
    if (hold2) m2v = m2v & ~s2_flush;
    else begin
      m2v = s1_wr & (int'(s1_waddr) < N) & ~s1_flush & ~s1_stall;
      m2a = s1_waddr;
    end
  endtask

  task automatic read_chk(string tag, int a, logic [W-1:0] exp);
    idle(); s2_rd = 1; s2_raddr = AW'(a); step();
    check(tag, 32'(rd_seen), 32'(exp));
  endtask

  task automatic inst_write(int a, logic [W-1:0] d);
    idle(); s1_wr = 1; s1_waddr = AW'(a); step();
    idle(); step();
    idle(); s3_wdata = d; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst_ni = 1'b0;
    for (int e = 0; e < N; e++) mem_m[e] = '0;
    m2v = 0; m3v = 0; m2a = '0; m3a = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset state
    for (int a = 0; a < N; a++) begin
      read_chk("R1 reset value", a, '0);
      check("R1 no hazard", 32'(hz_seen), 0);
    end

    // R2 and R7: write lands in stage 3, read of the same element stalls meanwhile
    idle(); s1_wr = 1; s1_waddr = 3'd2; step();
    idle(); step();
    idle(); s3_wdata = 16'hABCD; s2_rd = 1; s2_raddr = 3'd2; step();
    check("R7 hazard on pending write", 32'(hz_seen), 1);
    read_chk("R2 committed value", 2, 16'hABCD);

    // R5: stage-3 stall delays the commit
    idle(); s1_wr = 1; s1_waddr = 3'd3; step();
    idle(); step();
    idle(); s3_stall = 1; s3_wdata = 16'h1111; step();
    idle(); s2_rd = 1; s2_raddr = 3'd3; s3_wdata = 16'h2222; step();
    check("R5 no commit while stalled", 32'(rd_seen), 0);
    check("R5 hazard while pending", 32'(hz_seen), 1);
    read_chk("R5 commit after stall", 3, 16'h2222);

    // R6: flush in stage 3, 2, 1
    idle(); s1_wr = 1; s1_waddr = 3'd4; step();
    idle(); step();
    idle(); s3_flush = 1; s3_wdata = 16'h3333; step();
    read_chk("R6 stage-3 flush", 4, '0);
    idle(); s1_wr = 1; s1_waddr = 3'd4; step();
    idle(); s2_flush = 1; step();
    idle(); s3_wdata = 16'h3334; step();
    read_chk("R6 stage-2 flush", 4, '0);
    idle(); s1_wr = 1; s1_waddr = 3'd4; s1_flush = 1; step();
    idle(); step();
    idle(); s3_wdata = 16'h3335; step();
    read_chk("R6 stage-1 flush", 4, '0);

    // R3: stage-1 stall keeps the request out
    idle(); s1_wr = 1; s1_waddr = 3'd5; s1_stall = 1; step();
    idle(); step();
    idle(); s3_wdata = 16'h4444; step();
    read_chk("R3 stalled capture", 5, '0);

    // R4: stage-2 stall holds the write one extra cycle
    idle(); s1_wr = 1; s1_waddr = 3'd1; step();
    idle(); s2_stall = 1; s3_wdata = 16'h7777; step();
    idle(); s3_wdata = 16'h6666; step();
    read_chk("R4 no early commit", 1, '0);
    idle(); s1_wr = 1; s1_waddr = 3'd1; step();
    idle(); s2_stall = 1; step();
    idle(); step();
    idle(); s3_wdata = 16'h5555; step();
    read_chk("R4 commit after stage-2 hold", 1, 16'h5555);

    // R8: free-running port gated by stage 3
    idle(); ct_we = 1; ct_addr = 3'd0; ct_wdata = 16'h0AAA; s3_stall = 1; step();
    read_chk("R8 blocked by stall", 0, '0);
    idle(); ct_we = 1; ct_addr = 3'd0; ct_wdata = 16'h0AAA; step();
    read_chk("R8 free-running write", 0, 16'h0AAA);
    idle(); ct_we = 1; ct_addr = 3'd0; ct_wdata = 16'h0DDD; s3_flush = 1; step();
    read_chk("R8 blocked by flush", 0, 16'h0AAA);

    // R9: priority and parallel writes
    idle(); s1_wr = 1; s1_waddr = 3'd0; step();
    idle(); step();
    idle(); s3_wdata = 16'h0BBB; ct_we = 1; ct_addr = 3'd0; ct_wdata = 16'h0CCC; step();
    read_chk("R9 instruction wins", 0, 16'h0BBB);
    idle(); s1_wr = 1; s1_waddr = 3'd0; step();
    idle(); step();
    idle(); s3_wdata = 16'h0EEE; ct_we = 1; ct_addr = 3'd1; ct_wdata = 16'h0FFF; step();
    read_chk("R9 instruction element", 0, 16'h0EEE);
    read_chk("R9 free-running element", 1, 16'h0FFF);

    // R10: out-of-range addresses
    idle(); ct_we = 1; ct_addr = 3'd6; ct_wdata = 16'h1234; step();
    idle(); s1_wr = 1; s1_waddr = 3'd7; step();
    idle(); step();
    idle(); s3_wdata = 16'h5678; s2_rd = 1; s2_raddr = 3'd7; step();
    check("R10 no hazard", 32'(hz_seen), 0);
    read_chk("R10 read 6", 6, '0);
    read_chk("R10 read 7", 7, '0);
    inst_write(5, 16'h9999);
    read_chk("R2 write after out-of-range", 5, 16'h9999);

    // Seeded random phase against the model (R2..R11)
    for (int i = 0; i < 3000; i++) begin
      idle();
      s1_wr    = ($urandom % 2) == 0;
      s1_waddr = AW'($urandom);
      s1_stall = ($urandom % 5) == 0;
      s1_flush = ($urandom % 16) == 0;
      s2_rd    = ($urandom % 2) == 0;
      s2_raddr = AW'($urandom);
      s2_stall = ($urandom % 6) == 0;
      s2_flush = ($urandom % 16) == 0;
      s3_wdata = W'($urandom);
      s3_stall = ($urandom % 6) == 0;
      s3_flush = ($urandom % 16) == 0;
      ct_we    = ($urandom % 4) == 0;
      ct_addr  = AW'($urandom);
      ct_wdata = W'($urandom);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule